// File: doc/BRIEF.md
# Extended System-Control Register Access Checker

This block rules on every privileged access to an extended system-control register. The register has one storage copy for each of exception levels 1, 2 and 3. A fourth encoding is an alias, used from level 2 under host mode, that reaches the level-1 copy. The block takes the five-field access encoding, the direction, the current exception level, the control bits of the surrounding configuration registers and the implementation straps. From these it gives one outcome in the same cycle: allow, trap to EL2, trap to EL3, or undefined.

It also keeps the storage copies, commits a write only when the access is allowed, returns read data for allowed accesses, and records which copy the last recognised access selected. A feature-ID field shows whether the extended control feature is built in. Instruction decode and exception delivery belong to the surrounding pipeline.

Top module: `sysreg_ext_ctl`

## Requirements
- R1: Encodings (op0,op1,CRn,CRm,op2) map to copies as follows: (3,0,1,0,3) selects the level-1 copy, index 0. (3,4,1,0,3) selects the level-2 copy, index 1. (3,6,1,0,3) selects the level-3 copy, index 2. (3,5,1,0,3) is the alias and selects index 0. On the clock edge after a valid access with a matching encoding, `acc_reg_idx` holds that index.
- R2: While `strap_ext_ctl` is low, every access to any of the four encodings has outcome undefined. Outcome codes: 0 allow, 1 trap to EL2, 2 trap to EL3, 3 undefined.
- R3: For a level-1-copy access from EL1, the fine-grained check has the highest priority. When `el2_enabled` is set and either the virtual-memory trap bit for the direction (`hcr_trvm` for reads, `hcr_tvm` for writes) or the fine-grained bit for the direction (`fgt_rd_ctl`, `fgt_wr_ctl`) is set, the outcome is trap to EL2.
- R4: Otherwise, for a level-1-copy access from EL1 with `el2_enabled` set, the outcome is trap to EL2 when the extended hypervisor control is not enabled or bit 15 of `hcrx_val` is clear.
- R5: The extended hypervisor control is enabled only when `strap_hyp_ext` is set, `el2_enabled` is set, and, if `strap_el3` is set, bit 38 of `scr_val` is also set.
- R6: A level-1-copy access from EL1 that passes R3 and R4 traps to EL3 when `strap_el3` is set and bit 44 of `scr_val` is clear. Otherwise it is allowed.
- R7: From EL2, accesses to the level-1 or level-2 copy trap to EL3 under the same rule as R6. Otherwise they are allowed.
- R8: Alias accesses from EL2 or EL3 are undefined while `hcr_e2h` is clear. With `hcr_e2h` set, an alias access from EL2 follows the R7 rule and an alias access from EL3 is allowed. In both cases it reaches the level-1 copy.
- R9: The level-3 copy is accessible only from EL3. The level-1 copy is undefined from EL0. The level-2 copy and the alias are undefined from EL0 and EL1. Accesses from EL3 to the level-1 and level-2 copies are allowed.
- R10: `id_ext_field` reads 1 when `strap_ext_ctl` is set and 0 when it is clear.
- R11: An encoding outside the four listed has outcome undefined, and `acc_reg_idx` keeps its previous value.
- R12: A write updates the selected copy on the clock edge only when `acc_valid` is set and the outcome is allow. `acc_rdata` shows the selected copy when the outcome is allow and is zero otherwise.
- R13: Reset clears all storage copies and `acc_reg_idx` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_wdata | input | DATA_W | Write data |
| cur_el | input | 2 | Current exception level |
| strap_ext_ctl | input | 1 | Extended control feature implemented |
| strap_hyp_ext | input | 1 | Extended hypervisor control feature implemented |
| strap_el3 | input | 1 | EL3 implemented |
| el2_enabled | input | 1 | EL2 enabled in the current state |
| scr_val | input | CFG_W | Secure configuration register value |
| hcrx_val | input | CFG_W | Extended hypervisor configuration value |
| hcr_trvm | input | 1 | Hypervisor virtual-memory read trap |
| hcr_tvm | input | 1 | Hypervisor virtual-memory write trap |
| hcr_e2h | input | 1 | Host-mode enable |
| fgt_rd_ctl | input | 1 | Fine-grained read trap for system control |
| fgt_wr_ctl | input | 1 | Fine-grained write trap for system control |
| acc_outcome | output | 2 | 0 allow, 1 trap EL2, 2 trap EL3, 3 undefined |
| acc_rdata | output | DATA_W | Read data, zero unless allowed |
| acc_reg_idx | output | 2 | Copy index of the last recognised access |
| id_ext_field | output | ID_W | Feature-ID field |

## Verification
Directed sequences switch on one condition of the EL1 cascade at a time, always with a lower-priority condition also set. A fine-grained trap together with a cleared bit 44 must give EL2, not EL3, which shows that priority is respected and not simply merged. Separate patterns make the extended hypervisor control fail through each of its three terms, so each term is shown to matter. Distinct data written into each copy through EL3, then read back through the alias, tells correct folding apart from a stray fourth copy. Randomised encodings, levels, straps and configuration bits, with a bias toward the four valid encodings, are compared against a bench model of the outcome, read data and held index.

// File: rtl/sysreg_ext_pkg.sv
package sysreg_ext_pkg;
   typedef enum logic [1:0] {
      OUT_ALLOW    = 2'd0,
      OUT_TRAP_EL2 = 2'd1,
      OUT_TRAP_EL3 = 2'd2,
      OUT_UNDEF    = 2'd3
   } outcome_e;

   typedef enum logic [2:0] {
      SEL_NONE  = 3'd0,
      SEL_L1    = 3'd1,
      SEL_L2    = 3'd2,
      SEL_ALIAS = 3'd3,
      SEL_L3    = 3'd4
   } sel_e;

   // bit positions decoded from neighbouring configuration registers
   localparam int SCR_EXT_EN_BIT  = 44;
   localparam int SCR_HX_EN_BIT   = 38;
   localparam int HCRX_EXT_EN_BIT = 15;

   localparam int NUM_COPIES = 3;
   localparam int IDX_W      = 2;

   localparam logic [IDX_W-1:0] IDX_L1 = 2'd0;
   localparam logic [IDX_W-1:0] IDX_L2 = 2'd1;
   localparam logic [IDX_W-1:0] IDX_L3 = 2'd2;
endpackage

// File: rtl/sysreg_ext_decode.sv
module sysreg_ext_decode
   import sysreg_ext_pkg::*;
(
   input  logic [1:0] op0,
   input  logic [2:0] op1,
   input  logic [3:0] crn,
   input  logic [3:0] crm,
   input  logic [2:0] op2,
   output sel_e       sel
);
   logic base_hit;

   assign base_hit = (op0 == 2'd3) && (crn == 4'd1) && (crm == 4'd0) && (op2 == 3'd3);

   always_comb begin
      sel = SEL_NONE;
      if (base_hit) begin
         unique case (op1)
            3'd0:    sel = SEL_L1;
            3'd4:    sel = SEL_L2;
            3'd5:    sel = SEL_ALIAS;
            3'd6:    sel = SEL_L3;
            default: sel = SEL_NONE;
         endcase
      end
   end
endmodule

// File: rtl/sysreg_ext_trap_eval.sv
module sysreg_ext_trap_eval
   import sysreg_ext_pkg::*;
#(
   parameter int CFG_W = 64
) (
   input  sel_e             sel,
   input  logic [1:0]       cur_el,
   input  logic             is_write,
   input  logic             strap_ext_ctl,
   input  logic             strap_hyp_ext,
   input  logic             strap_el3,
   input  logic             el2_enabled,
   input  logic [CFG_W-1:0] scr_val,
   input  logic [CFG_W-1:0] hcrx_val,
   input  logic             hcr_trvm,
   input  logic             hcr_tvm,
   input  logic             hcr_e2h,
   input  logic             fgt_rd_ctl,
   input  logic             fgt_wr_ctl,
   output outcome_e         outcome,
   output logic [IDX_W-1:0] copy_idx
);
   logic el3_gate;
   logic hx_enabled;
   logic fine_trap;
   logic hx_trap;
   outcome_e el2_rule;

   assign el3_gate   = strap_el3 && !scr_val[SCR_EXT_EN_BIT];
   assign hx_enabled = strap_hyp_ext && el2_enabled &&
                       (!strap_el3 || scr_val[SCR_HX_EN_BIT]);
   assign fine_trap  = el2_enabled &&
                       (is_write ? (hcr_tvm || fgt_wr_ctl) : (hcr_trvm || fgt_rd_ctl));
   assign hx_trap    = el2_enabled && (!hx_enabled || !hcrx_val[HCRX_EXT_EN_BIT]);
   assign el2_rule   = el3_gate ? OUT_TRAP_EL3 : OUT_ALLOW;

   always_comb begin
      outcome = OUT_UNDEF;
      unique case (sel)
         SEL_L1: begin
            unique case (cur_el)
               2'd0: outcome = OUT_UNDEF;
               2'd1: begin
                  if (fine_trap)     outcome = OUT_TRAP_EL2;
                  else if (hx_trap)  outcome = OUT_TRAP_EL2;
                  else if (el3_gate) outcome = OUT_TRAP_EL3;
                  else               outcome = OUT_ALLOW;
               end
               2'd2:    outcome = el2_rule;
               default: outcome = OUT_ALLOW;
            endcase
         end
         SEL_L2: begin
            if (cur_el < 2'd2)       outcome = OUT_UNDEF;
            else if (cur_el == 2'd2) outcome = el2_rule;
            else                     outcome = OUT_ALLOW;
         end
         SEL_ALIAS: begin
            if (cur_el < 2'd2 || !hcr_e2h) outcome = OUT_UNDEF;
            else if (cur_el == 2'd2)       outcome = el2_rule;
            else                           outcome = OUT_ALLOW;
         end
         SEL_L3:  outcome = (cur_el == 2'd3) ? OUT_ALLOW : OUT_UNDEF;
         default: outcome = OUT_UNDEF;
      endcase
      if (!strap_ext_ctl) outcome = OUT_UNDEF;
   end

   always_comb begin
      unique case (sel)
         SEL_L2:  copy_idx = IDX_L2;
         SEL_L3:  copy_idx = IDX_L3;
         default: copy_idx = IDX_L1;
      endcase
   end
endmodule

// File: rtl/sysreg_ext_bank.sv
module sysreg_ext_bank
   import sysreg_ext_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int COPIES = NUM_COPIES
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         sel_idx,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [DATA_W-1:0]        rd_data,
   output logic [COPIES*DATA_W-1:0] copy_q
);
   logic [DATA_W-1:0] store [COPIES];

   for (genvar g = 0; g < COPIES; g++) begin : g_copy
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            store[g] <= '0;
         else if (wr_en && (sel_idx == IDX_W'(g)))
            store[g] <= wr_data;
      end
      assign copy_q[g*DATA_W +: DATA_W] = store[g];
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < COPIES; i++)
         if (sel_idx == IDX_W'(i)) rd_data = store[i];
   end
endmodule

// File: rtl/sysreg_ext_ctl.sv
module sysreg_ext_ctl
   import sysreg_ext_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CFG_W  = 64,
   parameter int ID_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [1:0]        acc_op0,
   input  logic [2:0]        acc_op1,
   input  logic [3:0]        acc_crn,
   input  logic [3:0]        acc_crm,
   input  logic [2:0]        acc_op2,
   input  logic              acc_write,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [1:0]        cur_el,
   input  logic              strap_ext_ctl,
   input  logic              strap_hyp_ext,
   input  logic              strap_el3,
   input  logic              el2_enabled,
   input  logic [CFG_W-1:0]  scr_val,
   input  logic [CFG_W-1:0]  hcrx_val,
   input  logic              hcr_trvm,
   input  logic              hcr_tvm,
   input  logic              hcr_e2h,
   input  logic              fgt_rd_ctl,
   input  logic              fgt_wr_ctl,
   output logic [1:0]        acc_outcome,
   output logic [DATA_W-1:0] acc_rdata,
   output logic [IDX_W-1:0]  acc_reg_idx,
   output logic [ID_W-1:0]   id_ext_field
);
   localparam int COPY_BITS = NUM_COPIES * DATA_W;

   if (CFG_W <= SCR_EXT_EN_BIT) begin : g_cfg_too_narrow
      $error("CFG_W must cover the highest decoded configuration bit");
   end
   if (DATA_W < 1) begin : g_data_too_narrow
      $error("DATA_W must be at least 1");
   end
   if (ID_W < 1) begin : g_id_too_narrow
      $error("ID_W must be at least 1");
   end

   sel_e             sel;
   outcome_e         outcome;
   logic [IDX_W-1:0] copy_idx;
   logic [DATA_W-1:0] bank_rdata;
   logic [COPY_BITS-1:0] copy_q;
   logic             allow;
   logic             hit;

   sysreg_ext_decode u_decode (
      .op0 (acc_op0),
      .op1 (acc_op1),
      .crn (acc_crn),
      .crm (acc_crm),
      .op2 (acc_op2),
      .sel (sel)
   );

   sysreg_ext_trap_eval #(.CFG_W(CFG_W)) u_eval (
      .sel           (sel),
      .cur_el        (cur_el),
      .is_write      (acc_write),
      .strap_ext_ctl (strap_ext_ctl),
      .strap_hyp_ext (strap_hyp_ext),
      .strap_el3     (strap_el3),
      .el2_enabled   (el2_enabled),
      .scr_val       (scr_val),
      .hcrx_val      (hcrx_val),
      .hcr_trvm      (hcr_trvm),
      .hcr_tvm       (hcr_tvm),
      .hcr_e2h       (hcr_e2h),
      .fgt_rd_ctl    (fgt_rd_ctl),
      .fgt_wr_ctl    (fgt_wr_ctl),
      .outcome       (outcome),
      .copy_idx      (copy_idx)
   );

   assign allow = (outcome == OUT_ALLOW);
   assign hit   = (sel != SEL_NONE);

   sysreg_ext_bank #(.DATA_W(DATA_W), .COPIES(NUM_COPIES)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc_valid && acc_write && allow),
      .sel_idx (copy_idx),
      .wr_data (acc_wdata),
      .rd_data (bank_rdata),
      .copy_q  (copy_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_reg_idx <= '0;
      else if (acc_valid && hit)
         acc_reg_idx <= copy_idx;
   end

   assign acc_outcome  = outcome;
   assign acc_rdata    = allow ? bank_rdata : '0;
   assign id_ext_field = strap_ext_ctl ? ID_W'(1) : '0;
endmodule

// File: rtl/sysreg_ext_ctl_chk.sv
module sysreg_ext_ctl_chk #(
   parameter int DATA_W = 64,
   parameter int ID_W   = 4,
   parameter int COPY_BITS = 3 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [1:0]        acc_op0,
   input logic [2:0]        acc_op1,
   input logic [3:0]        acc_crn,
   input logic [3:0]        acc_crm,
   input logic [2:0]        acc_op2,
   input logic              acc_write,
   input logic [1:0]        cur_el,
   input logic              strap_ext_ctl,
   input logic [1:0]        acc_outcome,
   input logic [DATA_W-1:0] acc_rdata,
   input logic [1:0]        acc_reg_idx,
   input logic [ID_W-1:0]   id_ext_field,
   input logic [COPY_BITS-1:0] copy_q
);
   logic base_ok;
   logic known_enc;
   assign base_ok   = (acc_op0 == 2'd3) && (acc_crn == 4'd1) &&
                      (acc_crm == 4'd0) && (acc_op2 == 3'd3);
   assign known_enc = base_ok && (acc_op1 == 3'd0 || acc_op1 == 3'd4 ||
                                  acc_op1 == 3'd5 || acc_op1 == 3'd6);

   p_undef_no_feature_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !strap_ext_ctl |-> acc_outcome == 2'd3);

   p_top_copy_el3_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && base_ok && acc_op1 == 3'd6 && cur_el != 2'd3 |-> acc_outcome == 2'd3);

   p_low_copy_not_el0_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && base_ok && acc_op1 == 3'd0 && cur_el == 2'd0 |-> acc_outcome == 2'd3);

   p_unknown_undef_r11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !known_enc |-> acc_outcome == 2'd3);

   p_idx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !known_enc |=> $stable(acc_reg_idx));

   p_no_commit_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_write && acc_outcome == 2'd0) |=> $stable(copy_q));

   p_rdata_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      acc_outcome != 2'd0 |-> acc_rdata == '0);

   p_id_field_r10: assert property (@(posedge clk) disable iff (!rst_n)
      id_ext_field == (strap_ext_ctl ? ID_W'(1) : ID_W'(0)));
endmodule

bind sysreg_ext_ctl sysreg_ext_ctl_chk #(
   .DATA_W(DATA_W), .ID_W(ID_W), .COPY_BITS(COPY_BITS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .acc_valid     (acc_valid),
   .acc_op0       (acc_op0),
   .acc_op1       (acc_op1),
   .acc_crn       (acc_crn),
   .acc_crm       (acc_crm),
   .acc_op2       (acc_op2),
   .acc_write     (acc_write),
   .cur_el        (cur_el),
   .strap_ext_ctl (strap_ext_ctl),
   .acc_outcome   (acc_outcome),
   .acc_rdata     (acc_rdata),
   .acc_reg_idx   (acc_reg_idx),
   .id_ext_field  (id_ext_field),
   .copy_q        (copy_q)
);

// File: tb/tb_sysreg_ext_ctl.sv
`timescale 1ns/1ps
module tb_sysreg_ext_ctl;
   localparam int DW = 64;
   localparam int CW = 64;
   localparam int IW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic valid = 1'b0;
   logic [1:0] op0 = '0;
   logic [2:0] op1 = '0;
   logic [3:0] crn = '0;
   logic [3:0] crm = '0;
   logic [2:0] op2 = '0;
   logic wr = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [1:0] el = '0;
   logic s_ext = 1'b1, s_hx = 1'b1, s_el3 = 1'b1, el2en = 1'b1;
   logic [CW-1:0] scr = '0, hcrx = '0;
   logic trvm = 1'b0, tvm = 1'b0, e2h = 1'b0, fgr = 1'b0, fgw = 1'b0;

   logic [1:0] outc;
   logic [DW-1:0] rdata;
   logic [1:0] ridx;
   logic [IW-1:0] idf;

   int checks = 0;
   int fails = 0;
   bit finished = 0;
   logic [DW-1:0] mcopy [3];
   logic [1:0] midx;

   always #2.5 clk = ~clk;

   sysreg_ext_ctl #(.DATA_W(DW), .CFG_W(CW), .ID_W(IW)) dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(valid),
      .acc_op0(op0), .acc_op1(op1), .acc_crn(crn), .acc_crm(crm), .acc_op2(op2),
      .acc_write(wr), .acc_wdata(wdata), .cur_el(el),
      .strap_ext_ctl(s_ext), .strap_hyp_ext(s_hx), .strap_el3(s_el3),
      .el2_enabled(el2en), .scr_val(scr), .hcrx_val(hcrx),
      .hcr_trvm(trvm), .hcr_tvm(tvm), .hcr_e2h(e2h),
      .fgt_rd_ctl(fgr), .fgt_wr_ctl(fgw),
      .acc_outcome(outc), .acc_rdata(rdata), .acc_reg_idx(ridx), .id_ext_field(idf)
   );

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // 0 none, 1 level-1, 2 level-2, 3 alias, 4 level-3
   function automatic int kind_of();
      if (!(op0 == 2'd3 && crn == 4'd1 && crm == 4'd0 && op2 == 3'd3)) return 0;
      case (op1)
         3'd0: return 1;
         3'd4: return 2;
         3'd5: return 3;
         3'd6: return 4;
         default: return 0;
      endcase
   endfunction

   function automatic logic [1:0] exp_out();
      int k = kind_of();
      bit b3, hx, fine;
      b3 = s_el3 && !scr[44];
      if (k == 0 || !s_ext) return 2'd3;
      if (k == 1) begin
         if (el == 0) return 2'd3;
         if (el == 1) begin
            fine = el2en && (wr ? (tvm || fgw) : (trvm || fgr));
            if (fine) return 2'd1;
            hx = s_hx && el2en && (!s_el3 || scr[38]);
            if (el2en && (!hx || !hcrx[15])) return 2'd1;
            return b3 ? 2'd2 : 2'd0;
         end
         if (el == 2) return b3 ? 2'd2 : 2'd0;
         return 2'd0;
      end
      if (k == 2) begin
         if (el < 2) return 2'd3;
         if (el == 2) return b3 ? 2'd2 : 2'd0;
         return 2'd0;
      end
      if (k == 3) begin
         if (el < 2 || !e2h) return 2'd3;
         if (el == 2) return b3 ? 2'd2 : 2'd0;
         return 2'd0;
      end
      return (el == 3) ? 2'd0 : 2'd3;
   endfunction

   function automatic int idx_of(int k);
      if (k == 2) return 1;
      if (k == 4) return 2;
      return 0;
   endfunction

   // present current inputs for one cycle and check everything
   task automatic step(input string req);
      logic [1:0] eo;
      int k;
      @(negedge clk);
      valid = 1'b1;
      #1;
      k = kind_of();
      eo = exp_out();
      chk(outc == eo, req, outc, eo);
      if (eo == 2'd0) chk(rdata == mcopy[idx_of(k)], {req, "/R12 rdata"}, rdata, mcopy[idx_of(k)]);
      else            chk(rdata == '0, {req, "/R12 rdata zero"}, rdata, '0);
      @(posedge clk);
      if (wr && eo == 2'd0) mcopy[idx_of(k)] = wdata;
      if (k != 0) midx = 2'(idx_of(k));
      #1;
      valid = 1'b0;
      chk(ridx == midx, {req, "/R1 R11 idx"}, ridx, midx);
   endtask

   task automatic enc(input logic [2:0] o1);
      op0 = 2'd3; crn = 4'd1; crm = 4'd0; op2 = 3'd3; op1 = o1;
   endtask

   task automatic base_cfg();
      s_ext = 1; s_hx = 1; s_el3 = 1; el2en = 1;
      scr = '0; scr[44] = 1; scr[38] = 1;
      hcrx = '0; hcrx[15] = 1;
      trvm = 0; tvm = 0; e2h = 1; fgr = 0; fgw = 0; wr = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 3; i++) mcopy[i] = '0;
      midx = '0;
      base_cfg();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R13: reset state read through EL3
      chk(ridx == 2'd0, "R13 idx reset", ridx, 0);
      el = 3; enc(3'd0); step("R13 L1 reset read");
      enc(3'd4); step("R13 L2 reset read");
      enc(3'd6); step("R13 L3 reset read");

      // R1: distinct data into each copy, alias reads level-1
      wr = 1;
      enc(3'd0); wdata = 64'h1111_aaaa_0000_0001; step("R1 write L1");
      enc(3'd4); wdata = 64'h2222_bbbb_0000_0002; step("R1 write L2");
      enc(3'd6); wdata = 64'h3333_cccc_0000_0003; step("R1 write L3");
      wr = 0;
      enc(3'd5); step("R1 R8 alias reads L1 from EL3");
      enc(3'd4); step("R1 read L2");
      enc(3'd6); step("R1 read L3");
      el = 2; enc(3'd5); wr = 1; wdata = 64'h4444; step("R8 alias write from EL2");
      wr = 0; el = 3; enc(3'd0); step("R1 R8 L1 after alias write");

      // R10
      #1 chk(idf == 4'd1, "R10 id field on", idf, 1);

      // R3: fine-grained beats lower-priority traps
      el = 1; enc(3'd0); scr[44] = 0; fgr = 1; step("R3 fgt read -> EL2");
      fgr = 0; trvm = 1; step("R3 trvm read -> EL2");
      trvm = 0; wr = 1; tvm = 1; wdata = 64'hdead; step("R3 tvm write -> EL2, no commit R12");
      tvm = 0; fgw = 1; step("R3 fgt write -> EL2");
      fgw = 0; wr = 0;

      // R4, R5
      scr[44] = 1; hcrx[15] = 0; step("R4 hcrx bit15 clear -> EL2");
      hcrx[15] = 1; scr[38] = 0; step("R5 hxen clear -> EL2");
      scr[38] = 1; s_hx = 0; step("R5 hyp-ext strap clear -> EL2");
      s_hx = 1; s_el3 = 0; scr[38] = 0; step("R5 no EL3, hxen ignored -> allow");
      s_el3 = 1; scr[38] = 1; step("R6 all enabled -> allow");

      // R6
      scr[44] = 0; step("R6 scr bit44 clear -> EL3");
      el2en = 0; trvm = 1; step("R6 EL2 disabled skips EL2 checks -> EL3");
      trvm = 0; scr[44] = 1; wr = 1; wdata = 64'h7777; step("R6 R12 EL1 write commits");
      wr = 0; el2en = 1;

      // R7
      el = 2; enc(3'd0); scr[44] = 0; step("R7 L1 from EL2 -> EL3");
      enc(3'd4); step("R7 L2 from EL2 -> EL3");
      s_el3 = 0; step("R7 no EL3 -> allow");
      s_el3 = 1; scr[44] = 1;

      // R8
      e2h = 0; enc(3'd5); step("R8 alias EL2 without e2h undef");
      el = 3; step("R8 alias EL3 without e2h undef");
      e2h = 1;

      // R9
      el = 0; enc(3'd0); step("R9 L1 from EL0 undef");
      el = 1; enc(3'd4); step("R9 L2 from EL1 undef");
      el = 2; enc(3'd6); step("R9 L3 from EL2 undef");
      el = 1; enc(3'd5); step("R9 alias from EL1 undef");

      // R11: unknown encodings hold idx
      el = 3; enc(3'd1); step("R11 op1=1 undef");
      enc(3'd0); op2 = 3'd2; step("R11 op2 mismatch undef");

      // R2
      s_ext = 0; enc(3'd6); wr = 1; wdata = 64'hbad; step("R2 feature off undef");
      wr = 0; enc(3'd0); step("R2 feature off L1");
      #1 chk(idf == 4'd0, "R10 id field off", idf, 0);
      s_ext = 1;

      // random mix
      for (int n = 0; n < 800; n++) begin
         if ($urandom_range(9) < 8) begin
            case ($urandom_range(3))
               0: enc(3'd0);
               1: enc(3'd4);
               2: enc(3'd5);
               default: enc(3'd6);
            endcase
         end else begin
            op0 = 2'($urandom); op1 = 3'($urandom); crn = 4'($urandom);
            crm = 4'($urandom); op2 = 3'($urandom);
         end
         el = 2'($urandom);
         wr = 1'($urandom);
         wdata = {$urandom, $urandom};
         s_ext = ($urandom_range(7) != 0);
         s_hx = 1'($urandom); s_el3 = 1'($urandom); el2en = 1'($urandom);
         scr = '0; scr[44] = 1'($urandom); scr[38] = 1'($urandom);
         hcrx = '0; hcrx[15] = 1'($urandom);
         trvm = ($urandom_range(3) == 0); tvm = ($urandom_range(3) == 0);
         fgr = ($urandom_range(3) == 0); fgw = ($urandom_range(3) == 0);
         e2h = 1'($urandom);
         step("R3 R4 R5 R6 R7 R8 R9 random");
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule